// File: doc/BRIEF.md
# Overlapped Virtual-Index Physical-Tag Cache Lookup

This block is the lookup front end of a 64 KB direct-mapped cache whose directory is addressed with virtual address bits while address translation runs alongside. A request carries a 32-bit virtual address. In the acceptance cycle the directory line is read at the virtual index and a small fully associative translation table is searched for the virtual page number. In the following cycle the stored tag is compared against the upper bits of the translated physical address. The response reports hit, the stored data word of the line, the physical address (needed by the refill side on a miss) and a flag when translation failed.

Requests and responses are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester holds `req_valid` and `req_vaddr` steady until that happens. A response stays on the outputs, unchanged, until the consumer takes it with `rsp_ready`. While a response waits, the pipeline freezes and no request is accepted. Translation entries and cache lines are written by plain control ports. A line fill whose virtual and physical bits 15:14 disagree raises a one-cycle synonym-risk flag, because the same physical line could then sit at a second index.

Top module: `vipt_lookup`

## Requirements
- R1: Address fields are split as follows. The line index is virtual bits 15:5, the page number is bits 31:14 above a 14-bit page offset, and the stored tag holds physical bits 31:16. A line whose tag differs from the translated address bits 31:16 gives a miss.
- R2: `req_ready` is high exactly when no response is waiting or `rsp_ready` is high. A request accepted on edge k has its response valid after edge k+1, provided the response stage advances on that edge. Responses leave in acceptance order, and one request can be taken per cycle.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_hit`, `rsp_tlb_miss`, `rsp_data` and `rsp_paddr` hold their values and `req_ready` stays low.
- R4: `rsp_hit` is high only when translation succeeded, the indexed line is valid and its stored tag equals the physical bits 31:16. On a hit, `rsp_data` is the word written by the last fill of that line.
- R5: On a translation hit, `rsp_paddr` is the translated page number followed by virtual bits 13:0. On a translation miss, `rsp_tlb_miss` is 1, `rsp_hit` is 0 and `rsp_paddr` is the page offset with zeros in bits 31:14.
- R6: A table write stores page number and frame number into the slot given by `tlb_wr_slot` and marks the slot valid. When several valid slots match, the lowest-numbered slot supplies the frame.
- R7: A fill writes the line at fill virtual bits 15:5, marks it valid, and stores physical bits 31:16 as the tag and `fill_data` as the word. Both fills and table writes are seen only by requests accepted on a later edge than the write.
- R8: `syn_risk` is high for the one cycle after an edge on which a fill had virtual bits 15:14 different from physical bits 15:14. It is low after every other edge.
- R9: After reset every line and every table slot is invalid, `rsp_valid` and `syn_risk` are low, and `req_ready` is high.
- R10: Because the index uses virtual bits, two virtual pages that map to the same frame but differ in bit 14 or 15 select different lines. A line filled through one of them is a miss through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken this edge |
| req_vaddr | input | 32 | Virtual address to look up |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result this edge |
| rsp_hit | output | 1 | Line present for the translated address |
| rsp_tlb_miss | output | 1 | No translation found for the page |
| rsp_data | output | 32 | Data word stored in the indexed line |
| rsp_paddr | output | 32 | Translated physical address |
| tlb_wr_en | input | 1 | Write one translation slot |
| tlb_wr_slot | input | 2 | Slot number to write |
| tlb_wr_vpn | input | 18 | Virtual page number for the slot |
| tlb_wr_ppn | input | 18 | Physical frame number for the slot |
| fill_en | input | 1 | Write one cache line |
| fill_vaddr | input | 32 | Virtual address selecting the line |
| fill_paddr | input | 32 | Physical address supplying the tag |
| fill_data | input | 32 | Data word for the line |
| syn_risk | output | 1 | Last fill placed a line at a virtual-only index |

## Verification
The assertions check several rules on every cycle. A waiting response stays frozen and request acceptance is blocked while it waits. A translation miss never carries a hit and reports a zero frame. Hit only appears with a valid response. The synonym flag follows each fill's bits 15:14 one cycle later. Whether hit and data are correct depends on what earlier fills and table writes left in storage, so only the bench's reference model and directed scenarios can show it. Those scenarios cover stale tags, aliasing virtual pages, slot priority, fills on the same edge as a lookup, and random traffic under back-pressure.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned PAGE_OFF_W = 14;
  localparam int unsigned LINE_OFF_W = 5;
  localparam int unsigned IDX_W      = 11;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned TLB_N      = 4;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int unsigned VPN_W  = 18,
  parameter int unsigned PPN_W  = 18,
  parameter int unsigned N      = 4,
  parameter int unsigned SLOT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn
);
  logic [N-1:0]     slot_vld;
  logic [VPN_W-1:0] slot_vpn [N];
  logic [PPN_W-1:0] slot_ppn [N];
  logic [N-1:0]     match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_vld <= '0;
    else if (wr_en) slot_vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_vpn[wr_slot] <= wr_vpn;
      slot_ppn[wr_slot] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = slot_vld[g] && (slot_vpn[g] == lk_vpn);
  end

  // lowest matching slot wins: scan downward so the last write is slot 0 side
  always_comb begin
    lk_hit = |match;
    lk_ppn = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) lk_ppn = slot_ppn[i];
    end
  end
endmodule

// File: rtl/vipt_dir.sv
module vipt_dir #(
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_vld <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) line_vld[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= line_vld[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_data <= data_mem[rd_idx];
    end
  end
endmodule

// File: rtl/vipt_cmp.sv
module vipt_cmp #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_OFF_W = 14,
  parameter int unsigned TAG_W      = 16,
  localparam int unsigned PPN_W     = ADDR_W - PAGE_OFF_W
) (
  input  logic                  line_vld,
  input  logic [TAG_W-1:0]      line_tag,
  input  logic                  xl_hit,
  input  logic [PPN_W-1:0]      xl_ppn,
  input  logic [PAGE_OFF_W-1:0] page_off,
  output logic                  hit,
  output logic                  xl_miss,
  output logic [ADDR_W-1:0]     paddr
);
  logic [TAG_W-1:0] phys_tag;

  always_comb begin
    paddr    = xl_hit ? {xl_ppn, page_off} : {{PPN_W{1'b0}}, page_off};
    phys_tag = paddr[ADDR_W-1 -: TAG_W];
    xl_miss  = !xl_hit;
    hit      = xl_hit && line_vld && (line_tag == phys_tag);
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned POW  = PAGE_OFF_W,
  parameter int unsigned LOW  = LINE_OFF_W,
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NTLB = TLB_N,
  localparam int unsigned PPN_W  = AW - POW,
  localparam int unsigned TAG_W  = AW - LOW - IW,
  localparam int unsigned IDX_HI = LOW + IW - 1,
  localparam int unsigned SLOT_W = (NTLB > 1) ? $clog2(NTLB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_tlb_miss,
  output logic [DW-1:0]     rsp_data,
  output logic [AW-1:0]     rsp_paddr,
  input  logic              tlb_wr_en,
  input  logic [SLOT_W-1:0] tlb_wr_slot,
  input  logic [PPN_W-1:0]  tlb_wr_vpn,
  input  logic [PPN_W-1:0]  tlb_wr_ppn,
  input  logic              fill_en,
  input  logic [AW-1:0]     fill_vaddr,
  input  logic [AW-1:0]     fill_paddr,
  input  logic [DW-1:0]     fill_data,
  output logic              syn_risk
);
  logic             advance;
  logic             xl_hit;
  logic [PPN_W-1:0] xl_ppn;

  logic             s1_valid;
  logic             s1_xl_hit;
  logic [PPN_W-1:0] s1_ppn;
  logic [POW-1:0]   s1_off;

  logic             line_vld;
  logic [TAG_W-1:0] line_tag;
  logic [DW-1:0]    line_data;

  logic             c_hit;
  logic             c_miss;
  logic [AW-1:0]    c_paddr;

  assign advance   = !rsp_valid || rsp_ready;
  assign req_ready = advance;

  // stage 1: translation searched while the directory is read at the virtual index
  vipt_tlb #(.VPN_W(PPN_W), .PPN_W(PPN_W), .N(NTLB), .SLOT_W(SLOT_W)) u_tlb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tlb_wr_en),
    .wr_slot(tlb_wr_slot),
    .wr_vpn (tlb_wr_vpn),
    .wr_ppn (tlb_wr_ppn),
    .lk_vpn (req_vaddr[AW-1:POW]),
    .lk_hit (xl_hit),
    .lk_ppn (xl_ppn)
  );

  vipt_dir #(.IDX_W(IW), .TAG_W(TAG_W), .DATA_W(DW)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (advance),
    .rd_idx  (req_vaddr[IDX_HI:LOW]),
    .rd_valid(line_vld),
    .rd_tag  (line_tag),
    .rd_data (line_data),
    .wr_en   (fill_en),
    .wr_idx  (fill_vaddr[IDX_HI:LOW]),
    .wr_tag  (fill_paddr[AW-1 -: TAG_W]),
    .wr_data (fill_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_xl_hit <= 1'b0;
      s1_ppn    <= '0;
      s1_off    <= '0;
    end else if (advance) begin
      s1_valid  <= req_valid;
      s1_xl_hit <= xl_hit;
      s1_ppn    <= xl_ppn;
      s1_off    <= req_vaddr[POW-1:0];
    end
  end

  // stage 2: physical tag compare
  vipt_cmp #(.ADDR_W(AW), .PAGE_OFF_W(POW), .TAG_W(TAG_W)) u_cmp (
    .line_vld(line_vld),
    .line_tag(line_tag),
    .xl_hit  (s1_xl_hit),
    .xl_ppn  (s1_ppn),
    .page_off(s1_off),
    .hit     (c_hit),
    .xl_miss (c_miss),
    .paddr   (c_paddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_data     <= '0;
      rsp_paddr    <= '0;
    end else if (advance) begin
      rsp_valid    <= s1_valid;
      rsp_hit      <= s1_valid && c_hit;
      rsp_tlb_miss <= s1_valid && c_miss;
      rsp_data     <= line_data;
      rsp_paddr    <= c_paddr;
    end
  end

  // index bits above the page offset come from the virtual page number
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syn_risk <= 1'b0;
    else syn_risk <= fill_en && (fill_vaddr[IDX_HI:POW] != fill_paddr[IDX_HI:POW]);
  end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned POW    = 14,
  parameter int unsigned IDX_HI = 15,
  parameter int unsigned DW     = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_hit,
  input logic          rsp_tlb_miss,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] rsp_paddr,
  input logic          fill_en,
  input logic [AW-1:0] fill_vaddr,
  input logic [AW-1:0] fill_paddr,
  input logic          syn_risk
);
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_tlb_miss)
                                   && $stable(rsp_data) && $stable(rsp_paddr)));

  p_stall_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  p_hit_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  p_xlmiss_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tlb_miss) |-> (!rsp_hit && rsp_paddr[AW-1:POW] == '0));

  p_syn_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_vaddr[IDX_HI:POW] != fill_paddr[IDX_HI:POW]) |=> syn_risk);

  p_syn_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && fill_vaddr[IDX_HI:POW] != fill_paddr[IDX_HI:POW]) |=> !syn_risk);
endmodule

bind vipt_lookup vipt_lookup_chk #(.AW(AW), .POW(POW), .IDX_HI(IDX_HI), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_hit     (rsp_hit),
  .rsp_tlb_miss(rsp_tlb_miss),
  .rsp_data    (rsp_data),
  .rsp_paddr   (rsp_paddr),
  .fill_en     (fill_en),
  .fill_vaddr  (fill_vaddr),
  .fill_paddr  (fill_paddr),
  .syn_risk    (syn_risk)
);

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic        rsp_tlb_miss;
  logic [31:0] rsp_data;
  logic [31:0] rsp_paddr;
  logic        tlb_wr_en = 1'b0;
  logic [1:0]  tlb_wr_slot = '0;
  logic [17:0] tlb_wr_vpn = '0;
  logic [17:0] tlb_wr_ppn = '0;
  logic        fill_en = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [31:0] fill_paddr = '0;
  logic [31:0] fill_data = '0;
  logic        syn_risk;

  always #5 clk = ~clk;

  vipt_lookup u_vipt_lookup (.*);

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    int          acc;
    bit          hit;
    bit          tm;
    bit [31:0]   data;
    bit [31:0]   pa;
  } exp_t;

  exp_t        q[$];
  int          edge_cnt = 0;
  bit          exp_syn = 0;
  bit          m_acc = 0;
  bit          prev_stall = 0;
  bit          m_lv  [int];
  bit [15:0]   m_tag [int];
  bit [31:0]   m_dat [int];
  bit          t_v   [4];
  bit [17:0]   t_vpn [4];
  bit [17:0]   t_ppn [4];

  function automatic exp_t predict(input bit [31:0] va);
    exp_t e;
    int   slot = -1;
    int   idx;
    for (int i = 3; i >= 0; i--) if (t_v[i] && t_vpn[i] == va[31:14]) slot = i;
    e.acc = edge_cnt;
    idx   = int'(va[15:5]);
    if (slot < 0) begin
      e.tm = 1; e.hit = 0; e.pa = {18'd0, va[13:0]};
    end else begin
      e.tm  = 0;
      e.pa  = {t_ppn[slot], va[13:0]};
      e.hit = m_lv.exists(idx) && m_tag[idx] == e.pa[31:16];
    end
    e.data = m_dat.exists(idx) ? m_dat[idx] : 32'd0;
    return e;
  endfunction

  function automatic bit exp_valid();
    return q.size() > 0 && (edge_cnt - q[0].acc) >= 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_lv.delete(); m_tag.delete(); m_dat.delete();
      for (int i = 0; i < 4; i++) t_v[i] = 0;
      exp_syn = 0; m_acc = 0; edge_cnt = 0;
    end else begin
      bit ev;
      ev = exp_valid();
      m_acc = req_valid && (!ev || rsp_ready);
      if (ev && rsp_ready) void'(q.pop_front());
      if (m_acc) q.push_back(predict(req_vaddr));
      if (tlb_wr_en) begin
        t_v[tlb_wr_slot] = 1; t_vpn[tlb_wr_slot] = tlb_wr_vpn; t_ppn[tlb_wr_slot] = tlb_wr_ppn;
      end
      if (fill_en) begin
        m_lv[int'(fill_vaddr[15:5])]  = 1;
        m_tag[int'(fill_vaddr[15:5])] = fill_paddr[31:16];
        m_dat[int'(fill_vaddr[15:5])] = fill_data;
      end
      exp_syn = fill_en && (fill_vaddr[15:14] != fill_paddr[15:14]);
      edge_cnt++;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = exp_valid();
      chk(rsp_valid == ev, prev_stall ? "R3 rsp_valid held" : "R2 rsp_valid timing", 32'(rsp_valid), 32'(ev));
      chk(req_ready == (!ev || rsp_ready), "R2 req_ready", 32'(req_ready), 32'(!ev || rsp_ready));
      chk(syn_risk == exp_syn, "R8 syn_risk", 32'(syn_risk), 32'(exp_syn));
      if (ev && rsp_valid) begin
        chk(rsp_hit == q[0].hit, "R4 rsp_hit", 32'(rsp_hit), 32'(q[0].hit));
        chk(rsp_tlb_miss == q[0].tm, "R5 rsp_tlb_miss", 32'(rsp_tlb_miss), 32'(q[0].tm));
        chk(rsp_paddr == q[0].pa, "R5 rsp_paddr", rsp_paddr, q[0].pa);
        if (q[0].hit) chk(rsp_data == q[0].data, "R4 rsp_data", rsp_data, q[0].data);
      end
      prev_stall = ev && !rsp_ready;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tlb_write(input bit [1:0] slot, input bit [17:0] vpn, input bit [17:0] ppn);
    @(posedge clk); #1;
    tlb_wr_en = 1; tlb_wr_slot = slot; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
    @(posedge clk); #1;
    tlb_wr_en = 0;
  endtask

  task automatic fill(input bit [31:0] va, input bit [31:0] pa, input bit [31:0] d);
    @(posedge clk); #1;
    fill_en = 1; fill_vaddr = va; fill_paddr = pa; fill_data = d;
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic lookup(input bit [31:0] va, output bit hit, output bit tm,
                        output bit [31:0] d, output bit [31:0] pa);
    @(posedge clk); #1;
    rsp_ready = 1; req_valid = 1; req_vaddr = va;
    @(posedge clk); #1;
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    hit = rsp_hit; tm = rsp_tlb_miss; d = rsp_data; pa = rsp_paddr;
  endtask

  function automatic bit [31:0] rand_va();
    bit [17:0] vpns [5] = '{18'd1, 18'd2, 18'd3, 18'd7, 18'h3FFFF};
    return {vpns[$urandom % 5], 2'b00, 12'(($urandom % 6) << 5 | ($urandom % 8) << 2)};
  endfunction

  function automatic bit [17:0] rand_ppn();
    bit [17:0] ppns [4] = '{18'd5, 18'h10, 18'h20, 18'h21};
    return ppns[$urandom % 4];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit hit, tm;
    bit [31:0] d, pa;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(req_ready == 1, "R9 req_ready after reset", 32'(req_ready), 1);
    chk(syn_risk == 0, "R9 syn_risk after reset", 32'(syn_risk), 0);

    tlb_write(2'd0, 18'd1, 18'd5);
    lookup(32'h0000_4124, hit, tm, d, pa);
    chk(hit == 0, "R9 lines invalid after reset", 32'(hit), 0);
    chk(tm == 0, "R9 translation found", 32'(tm), 0);

    fill(32'h0000_4120, 32'h0001_4120, 32'hCAFE_0001);
    chk(syn_risk == 0, "R8 matching bits 15:14", 32'(syn_risk), 0);
    lookup(32'h0000_4124, hit, tm, d, pa);
    chk(hit == 1, "R4 hit after fill", 32'(hit), 1);
    chk(d == 32'hCAFE_0001, "R4 data after fill", d, 32'hCAFE_0001);
    chk(pa == 32'h0001_4124, "R5 translated paddr", pa, 32'h0001_4124);

    // R1: stored tag 0x0002 vs physical bits 31:16 = 0x0001
    fill(32'h0000_4160, 32'h0002_4160, 32'h0000_0011);
    lookup(32'h0000_4160, hit, tm, d, pa);
    chk(hit == 0, "R1 tag mismatch on physical bits 31:16", 32'(hit), 0);

    // R10: second virtual page aliasing the same frame, index differs in bit 15
    tlb_write(2'd1, 18'd2, 18'd5);
    lookup(32'h0000_8124, hit, tm, d, pa);
    chk(hit == 0, "R10 alias selects another line", 32'(hit), 0);
    chk(pa == 32'h0001_4124, "R10 alias paddr", pa, 32'h0001_4124);
    fill(32'h0000_8120, 32'h0001_4120, 32'h0000_BEEF);
    chk(syn_risk == 1, "R8 synonym risk on fill", 32'(syn_risk), 1);
    @(posedge clk); #1;
    chk(syn_risk == 0, "R8 synonym flag lasts one cycle", 32'(syn_risk), 0);

    // R6: two slots with the same page, lowest slot wins
    tlb_write(2'd3, 18'd3, 18'h20);
    tlb_write(2'd2, 18'd3, 18'h10);
    lookup(32'h0000_C000, hit, tm, d, pa);
    chk(pa == 32'h0004_0000, "R6 lowest slot priority", pa, 32'h0004_0000);

    // R5: unmapped page
    lookup(32'hFFFF_0010, hit, tm, d, pa);
    chk(tm == 1, "R5 translation miss flag", 32'(tm), 1);
    chk(hit == 0, "R5 no hit on translation miss", 32'(hit), 0);
    chk(pa == 32'h0000_0010, "R5 paddr on translation miss", pa, 32'h0000_0010);

    // R7: fill on the acceptance edge is not seen by that lookup
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = 32'h0000_4144;
    fill_en = 1; fill_vaddr = 32'h0000_4140; fill_paddr = 32'h0001_4140; fill_data = 32'h7777_0000;
    @(posedge clk); #1;
    req_valid = 0; fill_en = 0;
    @(posedge clk); @(negedge clk);
    chk(rsp_hit == 0, "R7 same-edge fill not seen", 32'(rsp_hit), 0);
    lookup(32'h0000_4144, hit, tm, d, pa);
    chk(hit == 1 && d == 32'h7777_0000, "R7 later lookup sees fill", d, 32'h7777_0000);

    // R3: back-pressure holds the response and blocks requests
    @(posedge clk); #1;
    rsp_ready = 0; req_valid = 1; req_vaddr = 32'h0000_4124;
    @(posedge clk); #1;
    req_vaddr = 32'h0000_4124;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1, "R3 response waiting", 32'(rsp_valid), 1);
    chk(req_ready == 0, "R3 request blocked", 32'(req_ready), 0);
    chk(rsp_data == 32'hCAFE_0001, "R3 held data", rsp_data, 32'hCAFE_0001);
    @(posedge clk); #1;
    rsp_ready = 1; req_valid = 0;
    repeat (4) @(posedge clk);

    // random traffic with back-pressure, fills and table writes
    for (int n = 0; n < 1500; n++) begin
      @(posedge clk); #1;
      if (!req_valid || m_acc) begin
        req_valid = ($urandom % 3) != 0;
        req_vaddr = rand_va();
      end
      rsp_ready = ($urandom % 4) != 0;
      fill_en = ($urandom % 6) == 0;
      fill_vaddr = rand_va();
      fill_paddr = {rand_ppn(), fill_vaddr[13:0]};
      fill_data = $urandom;
      tlb_wr_en = ($urandom % 40) == 0;
      tlb_wr_slot = 2'($urandom);
      tlb_wr_vpn = 18'($urandom % 4);
      tlb_wr_ppn = rand_ppn();
    end
    @(posedge clk); #1;
    req_valid = 0; rsp_ready = 1; fill_en = 0; tlb_wr_en = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R2 all responses delivered", 32'(q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule